// File: doc/BRIEF.md
# 1-Wire ROM Command Controller

This block is the network-addressing layer of a single-wire bus slave. A bit-level signaling engine below it turns bus slots into simple events. A received write slot arrives as a one-cycle strobe carrying the sampled value. A read slot arrives as a one-cycle request, which the controller answers in the same cycle with the bit the engine should send. A detected reset pulse arrives as a one-cycle indication. After each bus reset the controller collects an 8-bit command, least significant bit first. It then runs one of four addressing operations against a 64-bit identity built at elaboration time.

The four operations are as follows. Identity read (33h) sends out the whole identity. Addressed match (55h) compares 64 master bits against the identity. Search arbitration (F0h) sends each identity bit, then its complement, then compares the bit the master picks. Skip (CCh) selects the device without any exchange. When addressing succeeds, the controller raises `fn_grant` and holds it, so the function layer can take over the bus. If addressing fails, or the command is unknown, the controller goes passive. It answers every read request with a released (1) bit until the next bus reset.

The bit engine cannot be stalled, because slot timing belongs to the master. Both bit streams are therefore valid-only, with no ready. The controller accepts a strobe in any cycle. It answers a read request combinationally in the same cycle, and a strobe it has no use for is dropped.

Top module: `owrom_ctrl`

## Requirements
- R1: The identity is 64 bits. Bits 7:0 hold the family code (default 24h) and bits 55:8 hold the serial-number parameter. Bits 63:56 hold a CRC-8 of bits 55:0, using polynomial x^8+x^5+x^4+1 with zero initial value and bits fed in from bit 0 upward, so a CRC pass over all 64 bits leaves zero.
- R2: After `rst_n` the controller is passive until the first `bus_rst`: `fn_grant` is 0 and command bits have no effect.
- R3: After `bus_rst`, the next 8 `rx_valid` strobes form the command byte, the first strobe being bit 0.
- R4: Under command 33h, the 64 following `tx_req` pulses are answered with identity bits 0 to 63 in order. `fn_grant` rises in the cycle after the 64th request.
- R5: Under command 55h, 64 received bits are compared with identity bits 0 to 63. If all are equal, `fn_grant` rises in the cycle after the 64th. On the first mismatch the controller goes passive, and later bits never raise `fn_grant`.
- R6: Under command F0h, each identity bit k takes three events. The first `tx_req` returns bit k, the second `tx_req` returns its inverse, and the next `rx_valid` is compared with bit k. A mismatch makes the controller passive. A full 64-bit match raises `fn_grant`.
- R7: Under command CCh, `fn_grant` rises in the cycle after the 8th command bit.
- R8: Any other command byte makes the controller passive until the next `bus_rst`.
- R9: `bus_rst` in any state aborts the operation. `fn_grant` is 0 the cycle after, and a new command byte is collected.
- R10: `tx_bit` is 1 whenever `tx_req` is low, and while passive or selected or collecting a command.
- R11: Once `fn_grant` is high, it stays high through any strobes or requests until `bus_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: bus reset detected |
| rx_valid | input | 1 | One-cycle strobe: a write slot was sampled |
| rx_bit | input | 1 | Value sampled in that write slot |
| tx_req | input | 1 | One-cycle request for the bit to send in a read slot |
| tx_bit | output | 1 | Bit to send, valid in the `tx_req` cycle; 1 means release |
| fn_grant | output | 1 | Device is addressed; function layer owns the bus |

## Verification
The assertions assume that the bit engine never raises `rx_valid` and `tx_req` in the same cycle. They also assume that `bus_rst` comes as a pulse that the engine issues in place of a slot event. The stimulus drives every event through one task that sets at most one of the three inputs in a cycle, with idle cycles between events. A reference model in the bench tracks the expected command phase, bit index and search step on every clock, and it compares `tx_bit` and `fn_grant` against the design.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

  localparam int ID_BITS = 64;
  localparam int IDX_W   = $clog2(ID_BITS);

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;

  typedef enum logic [2:0] {
    ST_HOLD,    // passive: waiting for a bus reset
    ST_CMD,     // collecting the command byte
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_SEL      // addressed, function layer owns the bus
  } owrom_state_e;

  typedef enum logic [1:0] {
    PH_BIT,
    PH_INV,
    PH_PICK
  } search_ph_e;

  // CRC-8, polynomial x^8+x^5+x^4+1, reflected form, data taken from bit 0 up
  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/owrom_identity.sv
module owrom_identity
  import owrom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h24,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_0A5C_3E91
) (
  input  logic [IDX_W-1:0] idx,
  output logic             id_bit
);
  localparam logic [55:0]        BODY    = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [ID_BITS-1:0] ID_WORD = {crc8_lsb(BODY), BODY};

  assign id_bit = ID_WORD[idx];
endmodule

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx #(
  parameter int CMD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic                done,
  output logic [CMD_BITS-1:0] next_byte
);
  localparam int CW = $clog2(CMD_BITS);

  logic [CMD_BITS-2:0] sh;
  logic [CW-1:0]       cnt;

  assign next_byte = {bit_in, sh};
  assign done      = shift_en && (cnt == CW'(CMD_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sh  <= '0;
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= next_byte[CMD_BITS-1:1];
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/owrom_bit_index.sv
module owrom_bit_index #(
  parameter int COUNT = 64,
  parameter int W     = $clog2(COUNT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] idx,
  output logic         last
);
  assign last = (idx == W'(COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clr)   idx <= '0;
    else if (inc)   idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/owrom_ctrl.sv
module owrom_ctrl
  import owrom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h24,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_0A5C_3E91
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_req,
  output logic tx_bit,
  output logic fn_grant
);
  owrom_state_e     st, st_nx;
  search_ph_e       ph, ph_nx;
  logic [IDX_W-1:0] idx;
  logic             idx_last, idx_clr, idx_inc;
  logic             id_bit;
  logic             cmd_shift, cmd_done;
  logic [7:0]       cmd_byte;

  owrom_identity #(.FAMILY_CODE(FAMILY_CODE), .SERIAL_NUM(SERIAL_NUM)) u_id (
    .idx    (idx),
    .id_bit (id_bit)
  );

  owrom_cmd_rx #(.CMD_BITS(8)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (bus_rst),
    .shift_en  (cmd_shift),
    .bit_in    (rx_bit),
    .done      (cmd_done),
    .next_byte (cmd_byte)
  );

  owrom_bit_index #(.COUNT(ID_BITS), .W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idx_clr),
    .inc   (idx_inc),
    .idx   (idx),
    .last  (idx_last)
  );

  always_comb begin
    st_nx     = st;
    ph_nx     = ph;
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    cmd_shift = 1'b0;
    tx_bit    = 1'b1;
    if (bus_rst) begin
      st_nx   = ST_CMD;
      ph_nx   = PH_BIT;
      idx_clr = 1'b1;
    end else begin
      unique case (st)
        ST_CMD: if (rx_valid) begin
          cmd_shift = 1'b1;
          if (cmd_done) begin
            idx_clr = 1'b1;
            ph_nx   = PH_BIT;
            case (cmd_byte)
              CMD_READ:   st_nx = ST_READ;
              CMD_MATCH:  st_nx = ST_MATCH;
              CMD_SEARCH: st_nx = ST_SEARCH;
              CMD_SKIP:   st_nx = ST_SEL;
              default:    st_nx = ST_HOLD;
            endcase
          end
        end
        ST_READ: if (tx_req) begin
          tx_bit  = id_bit;
          idx_inc = 1'b1;
          if (idx_last) st_nx = ST_SEL;
        end
        ST_MATCH: if (rx_valid) begin
          if (rx_bit != id_bit) st_nx = ST_HOLD;
          else begin
            idx_inc = 1'b1;
            if (idx_last) st_nx = ST_SEL;
          end
        end
        ST_SEARCH: begin
          unique case (ph)
            PH_BIT: if (tx_req) begin
              tx_bit = id_bit;
              ph_nx  = PH_INV;
            end
            PH_INV: if (tx_req) begin
              tx_bit = ~id_bit;
              ph_nx  = PH_PICK;
            end
            PH_PICK: if (rx_valid) begin
              if (rx_bit != id_bit) st_nx = ST_HOLD;
              else begin
                ph_nx   = PH_BIT;
                idx_inc = 1'b1;
                if (idx_last) st_nx = ST_SEL;
              end
            end
            default: ph_nx = PH_BIT;
          endcase
        end
        default: ;  // ST_HOLD, ST_SEL: inputs ignored, bus released
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HOLD;
      ph <= PH_BIT;
    end else begin
      st <= st_nx;
      ph <= ph_nx;
    end
  end

  assign fn_grant = (st == ST_SEL);

  // input contract of the bit engine
  input_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_req));

  // R9
  reset_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !fn_grant);

  // R11
  grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_grant && !bus_rst) |=> fn_grant);

  // R10
  tx_idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |-> tx_bit);

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> tx_bit);

  // R4
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fn_grant) |-> $past(rx_valid || tx_req));
endmodule

// File: tb/owrom_ctrl_tb.sv
module owrom_ctrl_tb;
  localparam logic [7:0]  FAM = 8'h24;
  localparam logic [47:0] SER = 48'h0000_0A5C_3E91;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic tx_bit, fn_grant;

  int tests = 0;
  int fails = 0;
  string cur_req = "R2";

  // reference model
  int   mode = 0;        // 0 passive, 1 command, 2 read, 3 match, 4 search, 5 granted
  int   nbits = 0;
  int   cmdv = 0;
  int   pos = 0;
  int   step3 = 0;
  logic exp_grant = 1'b0;
  logic [63:0] id_exp;
  logic last_tx;

  always #4 clk = ~clk;

  owrom_ctrl #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .fn_grant(fn_grant)
  );

  function automatic logic [7:0] ref_crc(input logic [63:0] w, input int n);
    logic [7:0] r = 0;
    for (int i = 0; i < n; i++) begin
      logic m = r[0] ^ w[i];
      r = {1'b0, r[7:1]};
      if (m) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic model_tx(input logic tq);
    if (!tq) return 1'b1;
    if (mode == 2) return id_exp[pos];
    if (mode == 4 && step3 == 0) return id_exp[pos];
    if (mode == 4 && step3 == 1) return ~id_exp[pos];
    return 1'b1;
  endfunction

  task automatic model_step(input logic rv, input logic rb, input logic tq, input logic br);
    if (br) begin
      mode = 1; nbits = 0; cmdv = 0; pos = 0; step3 = 0;
    end else if (mode == 1 && rv) begin
      cmdv = cmdv | (int'(rb) << nbits);
      nbits++;
      if (nbits == 8) begin
        pos = 0; step3 = 0;
        if (cmdv == 'h33) mode = 2;
        else if (cmdv == 'h55) mode = 3;
        else if (cmdv == 'hF0) mode = 4;
        else if (cmdv == 'hCC) mode = 5;
        else mode = 0;
      end
    end else if (mode == 2 && tq) begin
      pos++;
      if (pos == 64) mode = 5;
    end else if (mode == 3 && rv) begin
      if (rb !== id_exp[pos]) mode = 0;
      else begin pos++; if (pos == 64) mode = 5; end
    end else if (mode == 4) begin
      if (step3 < 2 && tq) step3++;
      else if (step3 == 2 && rv) begin
        if (rb !== id_exp[pos]) mode = 0;
        else begin step3 = 0; pos++; if (pos == 64) mode = 5; end
      end
    end
    exp_grant = (mode == 5);
  endtask

  task automatic step(input logic rv, input logic rb, input logic tq, input logic br);
    logic e;
    @(negedge clk);
    rx_valid = rv; rx_bit = rb; tx_req = tq; bus_rst = br;
    #1;
    e = model_tx(tq);
    last_tx = tx_bit;
    check(tx_bit, e, tq ? cur_req : "R10", "tx_bit");
    model_step(rv, rb, tq, br);
    @(posedge clk); #1;
    check(fn_grant, exp_grant, cur_req, "fn_grant");
    @(negedge clk);
    rx_valid = 0; tx_req = 0; bus_rst = 0; rx_bit = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) step(1'b1, b[i], 1'b0, 1'b0);
  endtask

  task automatic new_cmd(input logic [7:0] b);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    send_byte(b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] got;
    id_exp = {8'h00, SER, FAM};
    id_exp[63:56] = ref_crc(id_exp, 56);

    repeat (3) @(posedge clk);
    #1 check(fn_grant, 1'b0, "R2", "grant during reset");
    @(negedge clk) rst_n = 1'b1;

    // R2: passive after power-up, skip command has no effect
    cur_req = "R2";
    step(0, 0, 1, 0);
    send_byte(8'hCC);
    check(fn_grant, 1'b0, "R2", "grant after early command");

    // R7, R3: skip
    cur_req = "R7";
    new_cmd(8'hCC);
    check(fn_grant, 1'b1, "R7", "skip grant");
    // R11: later events ignored
    cur_req = "R11";
    step(0, 0, 1, 0);
    send_byte(8'h33);
    check(fn_grant, 1'b1, "R11", "grant held");

    // R4, R1: identity read
    cur_req = "R4";
    new_cmd(8'h33);
    got = '0;
    for (int k = 0; k < 64; k++) begin
      step(0, 0, 1, 0);
      got[k] = last_tx;
      if (k % 9 == 0) step(0, 0, 0, 0);
    end
    check(got[7:0], FAM, "R1", "family code");
    check(got[63:56], ref_crc(id_exp, 56), "R1", "crc byte");
    check(ref_crc(got, 64), 0, "R1", "crc residue");
    check(fn_grant, 1'b1, "R4", "grant after read");

    // R5: full match
    cur_req = "R5";
    new_cmd(8'h55);
    for (int k = 0; k < 64; k++) step(1, id_exp[k], 0, 0);
    check(fn_grant, 1'b1, "R5", "match grant");

    // R5: mismatch at bit 10
    new_cmd(8'h55);
    for (int k = 0; k < 64; k++) step(1, (k == 10) ? ~id_exp[k] : id_exp[k], 0, 0);
    step(0, 0, 1, 0);
    check(fn_grant, 1'b0, "R5", "no grant after mismatch");

    // R6: full search
    cur_req = "R6";
    new_cmd(8'hF0);
    for (int k = 0; k < 64; k++) begin
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      step(1, id_exp[k], 0, 0);
    end
    check(fn_grant, 1'b1, "R6", "search grant");

    // R6: search loses at bit 40
    new_cmd(8'hF0);
    for (int k = 0; k < 64; k++) begin
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      step(1, (k == 40) ? ~id_exp[k] : id_exp[k], 0, 0);
    end
    check(fn_grant, 1'b0, "R6", "no grant after lost search");

    // R8: unknown command
    cur_req = "R8";
    new_cmd(8'hA5);
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0);
    send_byte(8'hCC);
    check(fn_grant, 1'b0, "R8", "unknown command passive");

    // R9: reset mid-read, then skip; reset while granted
    cur_req = "R9";
    new_cmd(8'h33);
    for (int k = 0; k < 20; k++) step(0, 0, 1, 0);
    new_cmd(8'hCC);
    check(fn_grant, 1'b1, "R9", "grant after aborted read");
    step(0, 0, 0, 1);
    check(fn_grant, 1'b0, "R9", "grant cleared by bus reset");
    cur_req = "R3";
    send_byte(8'h33);
    step(0, 0, 1, 0);
    check(last_tx, id_exp[0], "R3", "command after reset decoded");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule